// File: doc/BRIEF.md
# USB Endpoint Handshake Response Controller

This block holds the control state of one full-speed USB device control endpoint and picks the handshake returned for each token the protocol engine reports. The state is a halt (STALL) flag, a NAK status flag and a two-bit maximum-packet-size code. Software writes the state through single-cycle strobes. A token strobe carries the token kind, and the answer comes out one clock later. It is one of ACK, NAK, STALL, or a data phase with transmit enable.

The halt flag can only be raised by software. The block drops it by itself when a SETUP token arrives. While the halt flag is up, it outranks the endpoint NAK status and both global NAK flags. SETUP is always acknowledged. The NAK status is raised by software or by the block on SETUP, and is cleared only by software. While it is set, no data is sent even if the transmit FIFO holds a packet. The endpoint-type field reads as control (00), and the active flag is always 1.

Top module: `ep_hs_ctrl`

## Requirements
- R1: `st_stall` is set by `sw_set_stall` and cleared, one clock after, by a SETUP token. A SETUP in the same cycle as `sw_set_stall` leaves it clear. Software has no clear strobe.
- R2: For IN and OUT tokens, a set halt flag yields `resp_code` = 2 (STALL), whatever the endpoint NAK status and the global NAK flags are.
- R3: A SETUP token (`tok_kind` = 0) is always answered with `resp_code` = 0 (ACK) and `tx_en` = 0, whatever the halt flag, NAK status, global flags and FIFO state are.
- R4: `st_nak` is set by `sw_set_nak` or by a SETUP token, and cleared by `sw_clr_nak`. When a set source and the clear strobe come in the same cycle, the set wins.
- R5: For an IN token (`tok_kind` = 1) with no halt: if NAK status or `gl_in_nak` is set, the answer is NAK (`resp_code` = 1) with `tx_en` = 0. Otherwise, with `fifo_avail` = 1 the answer is a data phase (`resp_code` = 3) with `tx_en` = 1, and with an empty FIFO it is NAK.
- R6: For an OUT token (`tok_kind` = 2) with no halt: if NAK status or `gl_out_nak` is set, the answer is NAK. Otherwise it is ACK. `gl_in_nak` and `fifo_avail` have no effect on OUT.
- R7: `max_pkt_bytes` decodes the code loaded by `sw_size_we`: 0 gives 64, 1 gives 32, 2 gives 16, 3 gives 8.
- R8: After reset, `st_stall`, `st_nak` and the size code are 0 (64 bytes) and `resp_valid` is 0. `st_type` always reads 0 and `st_active` always reads 1.
- R9: The response appears exactly one clock after the token strobe, with `resp_valid` high for one cycle. Token kind 3 and cycles with no token give `resp_valid` = 0 and `tx_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_set_stall | input | 1 | Software strobe that raises the halt flag |
| sw_set_nak | input | 1 | Software strobe that raises NAK status |
| sw_clr_nak | input | 1 | Software strobe that clears NAK status |
| sw_size_we | input | 1 | Load strobe for the size code |
| sw_size_code | input | 2 | Max-packet size code |
| gl_in_nak | input | 1 | Global NAK for IN tokens |
| gl_out_nak | input | 1 | Global NAK for OUT tokens |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | 0 SETUP, 1 IN, 2 OUT, 3 reserved |
| fifo_avail | input | 1 | Transmit FIFO holds a packet |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_code | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 data phase |
| tx_en | output | 1 | Transmit enable for the data phase |
| max_pkt_bytes | output | 7 | Decoded max packet size in bytes |
| st_stall | output | 1 | Halt flag status |
| st_nak | output | 1 | NAK status |
| st_active | output | 1 | Active endpoint flag, always 1 |
| st_type | output | 2 | Endpoint type, always 0 (control) |

## Verification
The bench builds the block with its default `MAX_PKT_BYTES` of 64, which gives a 7-bit byte count and all four size codes. With that configuration, every combination of halt flag, NAK status, both global NAK flags, FIFO state and the four token kinds is small enough to sweep in full. Each expected answer is derived arithmetically from the priority order. Separate sweeps cover the same-cycle conflicts between the set and clear strobes, SETUP against `sw_set_stall`, and every size code.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_IN    = 2'd1,
        TK_OUT   = 2'd2,
        TK_RSVD  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2,
        HS_DATA  = 2'd3
    } hs_e;

    typedef struct packed {
        logic       stall;
        logic       nak;
        logic [1:0] size_code;
    } ep_ctl_t;

    typedef struct packed {
        logic valid;
        hs_e  code;
        logic tx_en;
    } hs_resp_t;

    localparam logic [1:0] EP_TYPE_CONTROL = 2'b00;

    function automatic hs_resp_t pick_handshake(
        input logic       tok_v,
        input logic [1:0] kind,
        input ep_ctl_t    ctl,
        input logic       g_in_nak,
        input logic       g_out_nak,
        input logic       fifo_ready
    );
        hs_resp_t r;
        r.valid = 1'b0;
        r.code  = HS_ACK;
        r.tx_en = 1'b0;
        if (tok_v) begin
            case (kind)
                TK_SETUP: begin
                    r.valid = 1'b1;
                    r.code  = HS_ACK;
                end
                TK_IN: begin
                    r.valid = 1'b1;
                    if (ctl.stall)
                        r.code = HS_STALL;
                    else if (ctl.nak || g_in_nak || !fifo_ready)
                        r.code = HS_NAK;
                    else begin
                        r.code  = HS_DATA;
                        r.tx_en = 1'b1;
                    end
                end
                TK_OUT: begin
                    r.valid = 1'b1;
                    if (ctl.stall)
                        r.code = HS_STALL;
                    else if (ctl.nak || g_out_nak)
                        r.code = HS_NAK;
                    else
                        r.code = HS_ACK;
                end
                default: r.valid = 1'b0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ep_ctl_state.sv
module ep_ctl_state
    import ep_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_stall,
    input  logic       set_nak,
    input  logic       clr_nak,
    input  logic       setup_seen,
    input  logic       size_we,
    input  logic [1:0] size_code,
    output ep_ctl_t    ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (setup_seen)
                ctl.stall <= 1'b0;
            else if (set_stall)
                ctl.stall <= 1'b1;

            if (set_nak || setup_seen)
                ctl.nak <= 1'b1;
            else if (clr_nak)
                ctl.nak <= 1'b0;

            if (size_we)
                ctl.size_code <= size_code;
        end
    end

endmodule

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
    import ep_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tok_valid,
    input  logic [1:0] tok_kind,
    input  ep_ctl_t    ctl,
    input  logic       gl_in_nak,
    input  logic       gl_out_nak,
    input  logic       fifo_avail,
    output hs_resp_t   resp
);

    hs_resp_t resp_d;

    always_comb begin
        resp_d = pick_handshake(tok_valid, tok_kind, ctl,
                                gl_in_nak, gl_out_nak, fifo_avail);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp.valid <= 1'b0;
            resp.code  <= HS_ACK;
            resp.tx_en <= 1'b0;
        end else begin
            resp <= resp_d;
        end
    end

endmodule

// File: rtl/ep_size_dec.sv
module ep_size_dec #(
    parameter int MAX_PKT_BYTES = 64,
    localparam int PKT_W = $clog2(MAX_PKT_BYTES + 1)
) (
    input  logic [1:0]       code,
    output logic [PKT_W-1:0] bytes
);

    localparam logic [PKT_W-1:0] BASE = PKT_W'(MAX_PKT_BYTES);

    always_comb begin
        bytes = BASE >> code;
    end

endmodule

// File: rtl/ep_hs_ctrl.sv
module ep_hs_ctrl
    import ep_hs_pkg::*;
#(
    parameter int MAX_PKT_BYTES = 64,
    localparam int PKT_W = $clog2(MAX_PKT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_set_stall,
    input  logic             sw_set_nak,
    input  logic             sw_clr_nak,
    input  logic             sw_size_we,
    input  logic [1:0]       sw_size_code,
    input  logic             gl_in_nak,
    input  logic             gl_out_nak,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             fifo_avail,
    output logic             resp_valid,
    output logic [1:0]       resp_code,
    output logic             tx_en,
    output logic [PKT_W-1:0] max_pkt_bytes,
    output logic             st_stall,
    output logic             st_nak,
    output logic             st_active,
    output logic [1:0]       st_type
);

    ep_ctl_t  ctl;
    hs_resp_t resp;
    logic     setup_seen;

    assign setup_seen = tok_valid && (tok_kind == TK_SETUP);

    ep_ctl_state u_state (
        .clk       (clk),
        .rst       (rst),
        .set_stall (sw_set_stall),
        .set_nak   (sw_set_nak),
        .clr_nak   (sw_clr_nak),
        .setup_seen(setup_seen),
        .size_we   (sw_size_we),
        .size_code (sw_size_code),
        .ctl       (ctl)
    );

    ep_hs_decide u_decide (
        .clk       (clk),
        .rst       (rst),
        .tok_valid (tok_valid),
        .tok_kind  (tok_kind),
        .ctl       (ctl),
        .gl_in_nak (gl_in_nak),
        .gl_out_nak(gl_out_nak),
        .fifo_avail(fifo_avail),
        .resp      (resp)
    );

    ep_size_dec #(.MAX_PKT_BYTES(MAX_PKT_BYTES)) u_size (
        .code (ctl.size_code),
        .bytes(max_pkt_bytes)
    );

    assign resp_valid = resp.valid;
    assign resp_code  = resp.code;
    assign tx_en      = resp.tx_en;
    assign st_stall   = ctl.stall;
    assign st_nak     = ctl.nak;
    assign st_active  = 1'b1;
    assign st_type    = EP_TYPE_CONTROL;

    AST_SETUP_CLEARS_HALT: assert property (@(posedge clk) disable iff (rst)
        setup_seen |=> !st_stall) else $error("setup left halt set"); // R1

    AST_HALT_OUTRANKS_NAK: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && (tok_kind == TK_IN || tok_kind == TK_OUT) && st_stall)
        |=> (resp_valid && resp_code == HS_STALL)) else $error("halt lost"); // R2

    AST_SETUP_ACKED: assert property (@(posedge clk) disable iff (rst)
        setup_seen |=> (resp_valid && resp_code == HS_ACK && !tx_en))
        else $error("setup not acked"); // R3

    AST_NAK_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (sw_set_nak || setup_seen) |=> st_nak) else $error("nak set lost"); // R4

    AST_NAK_BLOCKS_TX: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_kind == TK_IN && (st_nak || gl_in_nak))
        |=> !tx_en) else $error("data sent under nak"); // R5

    AST_TX_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        tx_en |-> (resp_valid && resp_code == HS_DATA && $past(fifo_avail)))
        else $error("stray tx enable"); // R5

    AST_NO_TOKEN_NO_RESP: assert property (@(posedge clk) disable iff (rst)
        (!tok_valid || tok_kind == TK_RSVD) |=> (!resp_valid && !tx_en))
        else $error("response without token"); // R9

endmodule

// File: tb/tb_ep_hs_ctrl.sv
module tb_ep_hs_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       sw_set_stall, sw_set_nak, sw_clr_nak, sw_size_we;
    logic [1:0] sw_size_code;
    logic       gl_in_nak, gl_out_nak, tok_valid, fifo_avail;
    logic [1:0] tok_kind;
    logic       resp_valid, tx_en, st_stall, st_nak, st_active;
    logic [1:0] resp_code, st_type;
    logic [6:0] max_pkt_bytes;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ep_hs_ctrl dut (
        .clk(clk), .rst(rst),
        .sw_set_stall(sw_set_stall), .sw_set_nak(sw_set_nak),
        .sw_clr_nak(sw_clr_nak), .sw_size_we(sw_size_we),
        .sw_size_code(sw_size_code), .gl_in_nak(gl_in_nak),
        .gl_out_nak(gl_out_nak), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .fifo_avail(fifo_avail), .resp_valid(resp_valid), .resp_code(resp_code),
        .tx_en(tx_en), .max_pkt_bytes(max_pkt_bytes), .st_stall(st_stall),
        .st_nak(st_nak), .st_active(st_active), .st_type(st_type)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        sw_set_stall = 0; sw_set_nak = 0; sw_clr_nak = 0; sw_size_we = 0;
        sw_size_code = 0; tok_valid = 0; tok_kind = 0;
    endtask

    task automatic do_reset();
        idle(); gl_in_nak = 0; gl_out_nak = 0; fifo_avail = 0;
        rst = 1; tick(); rst = 0;
    endtask

    initial begin
        rst = 1;
        idle(); gl_in_nak = 0; gl_out_nak = 0; fifo_avail = 0;
        tick(); tick();
        rst = 0;
        // R8 reset state
        chk("R8 stall", st_stall, 0);
        chk("R8 nak", st_nak, 0);
        chk("R8 size", max_pkt_bytes, 64);
        chk("R8 valid", resp_valid, 0);
        chk("R8 type", st_type, 0);
        chk("R8 active", st_active, 1);

        // Full sweep of halt, nak, globals, fifo, token kind (R2 R3 R5 R6 R9 R1)
        for (int v = 0; v < 128; v++) begin
            int s, n, gi, go, f, k, ec, ev, et, es, en;
            s = v & 1; n = (v >> 1) & 1; gi = (v >> 2) & 1;
            go = (v >> 3) & 1; f = (v >> 4) & 1; k = (v >> 5) & 3;
            do_reset();
            sw_set_stall = s[0]; sw_set_nak = n[0]; tick(); idle();
            gl_in_nak = gi[0]; gl_out_nak = go[0]; fifo_avail = f[0];
            tok_valid = 1; tok_kind = k[1:0];
            tick(); idle();
            ev = (k == 3) ? 0 : 1; et = 0; ec = 0; es = s; en = n;
            if (k == 0) begin ec = 0; es = 0; en = 1; end
            else if (k == 1) begin
                if (s == 1) ec = 2;
                else if (n == 1 || gi == 1 || f == 0) ec = 1;
                else begin ec = 3; et = 1; end
            end else if (k == 2) begin
                if (s == 1) ec = 2;
                else if (n == 1 || go == 1) ec = 1;
                else ec = 0;
            end
            chk("R9 resp_valid", resp_valid, ev);
            if (ev == 1) begin
                if (k == 0) chk("R3 setup code", resp_code, ec);
                else if (s == 1) chk("R2 stall code", resp_code, ec);
                else if (k == 1) chk("R5 in code", resp_code, ec);
                else chk("R6 out code", resp_code, ec);
            end
            chk("R5 tx_en", tx_en, et);
            chk("R1 stall after", st_stall, es);
            chk("R4 nak after", st_nak, en);
            tick();
            chk("R9 one-cycle valid", resp_valid, 0);
        end

        // R4 set/clear strobe conflicts
        for (int v = 0; v < 8; v++) begin
            int pre, st, cl, exp;
            pre = v & 1; st = (v >> 1) & 1; cl = (v >> 2) & 1;
            do_reset();
            sw_set_nak = pre[0]; tick(); idle();
            sw_set_nak = st[0]; sw_clr_nak = cl[0]; tick(); idle();
            exp = (st == 1) ? 1 : ((cl == 1) ? 0 : pre);
            chk("R4 nak strobes", st_nak, exp);
        end
        // R4 setup vs clear in same cycle
        do_reset();
        sw_clr_nak = 1; tok_valid = 1; tok_kind = 0; tick(); idle();
        chk("R4 setup beats clear", st_nak, 1);

        // R1 setup same cycle as set_stall
        do_reset();
        sw_set_stall = 1; tok_valid = 1; tok_kind = 0; tick(); idle();
        chk("R1 setup beats set", st_stall, 0);
        // R1 stall persists without setup
        do_reset();
        sw_set_stall = 1; tick(); idle();
        sw_clr_nak = 1; tick(); tick(); idle();
        chk("R1 stall held", st_stall, 1);

        // R7 size decode
        for (int c = 0; c < 4; c++) begin
            do_reset();
            sw_size_we = 1; sw_size_code = c[1:0]; tick(); idle();
            chk("R7 size", max_pkt_bytes, 64 >> c);
            sw_size_code = 2'(3 - c); tick();
            chk("R7 no write held", max_pkt_bytes, 64 >> c);
            chk("R8 active held", st_active, 1);
            chk("R8 type held", st_type, 0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule